// File: doc/BRIEF.md
# Frame-truncating receive FIFO

This block sits between a MAC receive path and a client that consumes packets. Bytes arrive one per cycle with start, end, valid and error markers. They are stored in a synchronous FIFO and handed to the client over a valid/ready stream. The stream carries the same markers plus a truncation flag.

When the client falls behind, the block watches the fill level against a programmable almost-full threshold. If the level reaches the threshold while a frame is being written, the block writes one closing entry instead of the current byte. That entry marks the end of the frame with both the error flag and the truncation flag set. The rest of that frame is then thrown away, so the client always sees a properly closed frame. A new frame is accepted only if the level is below the threshold when its start arrives. A real overflow is a write while the store is full, which can only happen when the threshold equals the depth. It raises a sticky fatal flag that blocks every write until a flush or reset.

Top module: `rx_trunc_fifo`

## Requirements
- R1: `level` equals the number of stored entries. `out_valid` is 1 exactly when `level` is nonzero. An entry leaves only on a cycle where `out_valid` and `out_ready` are both 1.
- R2: Accepted bytes reach the client in arrival order, with `out_data`, `out_sof` and `out_eof` equal to the input values of that beat.
- R3: A valid beat inside a frame that arrives while `level` is at or above the frame's threshold is replaced by one entry with data 0x00, `out_eof`=1, `out_err`=1 and `out_trunc`=1. All later beats of that frame are discarded.
- R4: `out_trunc` is 1 only on that closing entry, and the closing entry always has `out_eof` and `out_err` at 1.
- R5: `in_err` on a stored beat appears unchanged as `out_err` on that entry.
- R6: Outside a frame, only a beat with `in_sof`=1 is considered. It is stored only if `level` < `af_thresh`; otherwise the whole frame is dropped. Other beats outside a frame leave `level` unchanged.
- R7: A write request while `level` equals the depth is dropped and sets `fatal_ovf`. `fatal_ovf` stays 1 and no entry is written until `flush` or `rst`. Reads continue meanwhile.
- R8: `flush`=1 at a clock edge empties the FIFO, clears `fatal_ovf` and returns the write side to between-frame state.
- R9: The threshold is captured at the start beat of a frame. Changes to `af_thresh` during the frame have no effect until the next start beat.
- R10: After reset, `out_valid`=0, `level`=0 and `fatal_ovf`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the FIFO and clear the fatal flag |
| in_valid | input | 1 | Input beat present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_err | input | 1 | Error on this byte |
| af_thresh | input | LVL_W | Almost-full threshold |
| out_ready | input | 1 | Client accepts the entry |
| out_valid | output | 1 | Entry present |
| out_data | output | 8 | Entry byte |
| out_sof | output | 1 | Entry starts a frame |
| out_eof | output | 1 | Entry ends a frame |
| out_err | output | 1 | Entry carries an error |
| out_trunc | output | 1 | Entry closes a truncated frame |
| fatal_ovf | output | 1 | Sticky overflow flag |
| level | output | LVL_W | Number of stored entries |

## Verification
The bench builds the block with a depth of 8, so a stalled client fills the store within a few beats. Truncation, whole-frame rejection and a threshold change inside a frame each take only a handful of cycles to reach. Setting the threshold equal to the depth is the only way to reach a true overflow, and the bench uses it to exercise the sticky fatal flag and its release by flush. A final phase uses a random ready pattern and random thresholds between 3 and 8, with a cycle-accurate queue model compared on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sof;
        logic              eof;
        logic              err;
        logic              trunc;
    } rxf_entry_t;

    typedef enum logic {ST_GAP, ST_FRAME} rxf_state_t;

    function automatic rxf_entry_t close_marker();
        rxf_entry_t m;
        m.data  = '0;
        m.sof   = 1'b0;
        m.eof   = 1'b1;
        m.err   = 1'b1;
        m.trunc = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl
    import rxf_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              fatal,
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  thr_in,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_err,
    output logic              wr_en,
    output rxf_entry_t        wr_entry
);
    rxf_state_t       state, state_nxt;
    logic [LVL_W-1:0] thr_q;
    rxf_entry_t       beat;

    always_comb begin
        beat.data  = in_data;
        beat.sof   = in_sof;
        beat.eof   = in_eof;
        beat.err   = in_err;
        beat.trunc = 1'b0;
    end

    always_comb begin
        wr_en     = 1'b0;
        wr_entry  = '0;
        state_nxt = state;
        if (in_valid && !fatal) begin
            if (state == ST_GAP) begin
                if (in_sof && (level < thr_in)) begin
                    wr_en     = 1'b1;
                    wr_entry  = beat;
                    state_nxt = in_eof ? ST_GAP : ST_FRAME;
                end
            end else if (level >= thr_q) begin
                wr_en     = 1'b1;
                wr_entry  = close_marker();
                state_nxt = ST_GAP;
            end else begin
                wr_en     = 1'b1;
                wr_entry  = beat;
                state_nxt = in_eof ? ST_GAP : ST_FRAME;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_GAP;
            thr_q <= '0;
        end else if (flush) begin
            state <= ST_GAP;
            thr_q <= thr_in;
        end else begin
            state <= state_nxt;
            if (state != ST_FRAME) thr_q <= thr_in;
        end
    end

    // R9: threshold held for the whole frame
    p_thr_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FRAME && !flush) |=> (state != ST_FRAME || $stable(thr_q)));

    // R6: nothing written between frames without a start marker
    p_gap_needs_sof_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && wr_en) |-> (in_sof && level < thr_in));
endmodule

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1),
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  rxf_entry_t       wr_entry,
    input  logic             rd_en,
    output rxf_entry_t       rd_entry,
    output logic [LVL_W-1:0] level,
    output logic             fatal
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    rxf_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] count;
    logic             full, empty, do_wr, do_rd;

    assign full     = (count == FULL_LVL);
    assign empty    = (count == '0);
    assign do_wr    = wr_en && !full;
    assign do_rd    = rd_en && !empty;
    assign rd_entry = mem[rd_ptr];
    assign level    = count;

    always_ff @(posedge clk) begin
        if (do_wr && !rst && !flush) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            fatal  <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            count <= count + LVL_W'(do_wr) - LVL_W'(do_rd);
            if (wr_en && full) fatal <= 1'b1;
        end
    end

    // R1: occupancy never exceeds the depth
    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_LVL);

    // R7: while the fatal flag is up the level never grows
    p_no_growth_fatal_r7: assert property (@(posedge clk) disable iff (rst)
        fatal |=> count <= $past(count));

    // R7: fatal flag stays until flush
    p_fatal_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (fatal && !flush) |=> fatal);
endmodule

// File: rtl/rx_trunc_fifo.sv
module rx_trunc_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_err,
    input  logic [LVL_W-1:0]  af_thresh,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err,
    output logic              out_trunc,
    output logic              fatal_ovf,
    output logic [LVL_W-1:0]  level
);
    logic       wr_en;
    rxf_entry_t wr_entry, rd_entry;

    rxf_wr_ctrl #(.LVL_W(LVL_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .fatal    (fatal_ovf),
        .level    (level),
        .thr_in   (af_thresh),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_err   (in_err),
        .wr_en    (wr_en),
        .wr_entry (wr_entry)
    );

    rxf_store #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_entry (wr_entry),
        .rd_en    (out_ready),
        .rd_entry (rd_entry),
        .level    (level),
        .fatal    (fatal_ovf)
    );

    assign out_valid = (level != '0);
    assign out_data  = rd_entry.data;
    assign out_sof   = rd_entry.sof;
    assign out_eof   = rd_entry.eof;
    assign out_err   = rd_entry.err;
    assign out_trunc = rd_entry.trunc;

    // R4: a truncation entry always closes its frame with an error
    p_trunc_closes_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_trunc) |-> (out_eof && out_err));

    // R8: flush leaves an empty FIFO and a clear fatal flag
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0 && !fatal_ovf));
endmodule

// File: tb/sim_rx_trunc_fifo.sv
`timescale 1ns/1ps
module sim_rx_trunc_fifo;
    localparam int DEPTH = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, flush, in_valid, in_sof, in_eof, in_err, out_ready;
    logic [7:0] in_data, out_data;
    logic [LVL_W-1:0] af_thresh, level;
    logic out_valid, out_sof, out_eof, out_err, out_trunc, fatal_ovf;

    rx_trunc_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
        .af_thresh(af_thresh), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .out_err(out_err), .out_trunc(out_trunc), .fatal_ovf(fatal_ovf),
        .level(level)
    );

    typedef struct packed {logic [7:0] d; logic s; logic e; logic r; logic t;} ent_t;
    ent_t q[$];
    bit   m_frame, m_fatal;
    int   m_thr;
    int   checks = 0, errors = 0;
    int   rdy_mode = 1;
    bit   done = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk("R1 out_valid", int'(out_valid), int'(q.size() > 0));
        chk("R1 level", int'(level), q.size());
        chk("R7 fatal_ovf", int'(fatal_ovf), int'(m_fatal));
        if (q.size() > 0) begin
            chk("R2 out_data", int'(out_data), int'(q[0].d));
            chk("R2 out_sof", int'(out_sof), int'(q[0].s));
            chk("R2 out_eof", int'(out_eof), int'(q[0].e));
            chk("R5 out_err", int'(out_err), int'(q[0].r));
            chk("R4 out_trunc", int'(out_trunc), int'(q[0].t));
        end
    endtask

    task automatic model_step();
        int   lvl = q.size();
        bit   wr = 0;
        bit   was_frame = m_frame;
        ent_t e;
        if (flush) begin
            q.delete();
            m_fatal = 0;
            m_frame = 0;
            m_thr   = int'(af_thresh);
            return;
        end
        e = '{d: in_data, s: in_sof, e: in_eof, r: in_err, t: 1'b0};
        if (in_valid && !m_fatal) begin
            if (!m_frame) begin
                if (in_sof && lvl < int'(af_thresh)) begin
                    wr = 1;
                    m_frame = !in_eof;
                end
            end else if (lvl >= m_thr) begin
                wr = 1;
                e = '{d: 8'h00, s: 1'b0, e: 1'b1, r: 1'b1, t: 1'b1};
                m_frame = 0;
            end else begin
                wr = 1;
                m_frame = !in_eof;
            end
        end
        if (wr && lvl == DEPTH) begin
            m_fatal = 1;
            wr = 0;
        end
        if (lvl > 0 && out_ready) void'(q.pop_front());
        if (wr) q.push_back(e);
        if (!was_frame) m_thr = int'(af_thresh);
    endtask

    task automatic step();
        #1;
        compare();
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ready();
        case (rdy_mode)
            0: out_ready = 1'b0;
            1: out_ready = 1'b1;
            default: out_ready = ($urandom % 3) != 0;
        endcase
    endtask

    task automatic beat(input logic [7:0] d, input logic s, input logic e, input logic r);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_err = r;
        set_ready();
        step();
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            set_ready();
            step();
        end
    endtask

    task automatic frame(int len, bit err_end, logic [7:0] base);
        for (int i = 0; i < len; i++)
            beat(base + 8'(i), i == 0, i == len - 1, err_end && (i == len - 1));
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; flush = 0; in_valid = 0; in_data = 0; in_sof = 0; in_eof = 0;
        in_err = 0; out_ready = 0; af_thresh = LVL_W'(7);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        q.delete(); m_frame = 0; m_fatal = 0; m_thr = 0;
        // R10: reset state
        chk("R10 out_valid", int'(out_valid), 0);
        chk("R10 level", int'(level), 0);
        chk("R10 fatal_ovf", int'(fatal_ovf), 0);

        // R2 R5: pass-through with a fast client
        rdy_mode = 1;
        frame(1, 0, 8'h10);
        frame(3, 1, 8'h20);
        frame(5, 0, 8'h30);
        idle(4);

        // R3: stalled client, threshold 5, long frame is cut
        rdy_mode = 0; af_thresh = LVL_W'(5);
        frame(10, 0, 8'h40);
        chk("R3 level after cut", int'(level), 6);
        chk("R3 no overflow", int'(fatal_ovf), 0);
        // R6: new frame refused at threshold, stray beat ignored
        frame(3, 0, 8'h60);
        chk("R6 level after refused frame", int'(level), 6);
        beat(8'h77, 0, 0, 0);
        chk("R6 level after stray beat", int'(level), 6);
        rdy_mode = 1;
        idle(8);
        chk("R1 drained", int'(level), 0);

        // R9: threshold lowered mid-frame has no effect on that frame
        rdy_mode = 0; af_thresh = LVL_W'(6);
        beat(8'h90, 1, 0, 0);
        af_thresh = LVL_W'(2);
        beat(8'h91, 0, 0, 0);
        beat(8'h92, 0, 0, 0);
        beat(8'h93, 0, 0, 0);
        beat(8'h94, 0, 1, 0);
        chk("R9 whole frame kept", int'(level), 5);
        rdy_mode = 1;
        idle(7);
        rdy_mode = 0;
        frame(4, 0, 8'hA0);
        chk("R9 new threshold at next frame", int'(level), 3);
        rdy_mode = 1;
        idle(5);

        // R7: threshold equal to depth reaches a true overflow
        rdy_mode = 0; af_thresh = LVL_W'(8);
        frame(12, 0, 8'hB0);
        chk("R7 fatal set", int'(fatal_ovf), 1);
        chk("R7 level full", int'(level), 8);
        rdy_mode = 1;
        idle(3);
        frame(2, 0, 8'hC0);
        chk("R7 writes blocked", int'(level), 3);
        chk("R7 fatal sticky", int'(fatal_ovf), 1);
        // R8: flush clears everything
        flush = 1; rdy_mode = 0;
        idle(1);
        flush = 0;
        chk("R8 level after flush", int'(level), 0);
        chk("R8 fatal after flush", int'(fatal_ovf), 0);
        rdy_mode = 1; af_thresh = LVL_W'(7);
        frame(2, 1, 8'hD0);
        idle(3);

        // mixed random traffic
        rdy_mode = 2;
        void'($urandom(7));
        for (int f = 0; f < 60; f++) begin
            af_thresh = LVL_W'(3 + ($urandom % 6));
            frame(1 + ($urandom % 9), ($urandom % 4) == 0, 8'(f * 16));
            idle($urandom % 3);
            if (f % 10 == 9) begin
                flush = 1;
                idle(1);
                flush = 0;
            end
        end
        rdy_mode = 1;
        idle(12);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule